// File: doc/BRIEF.md
# Transfer Controller Activation and Vector Unit

This unit sits between a set of peripheral interrupt request lines and a data transfer engine. Each source has an enable bit. An enabled source is routed to the transfer engine and never reaches the CPU interrupt path. A disabled source is forwarded to the CPU on `cpu_irq`. Software can also start a transfer through a one-byte activation register. That register holds a request flag in bit 7 and a 7-bit vector number in bits 6:0.

When the unit is idle and at least one activation is pending, it picks a single winner by fixed priority. It fetches that winner's 16-bit vector word over a request/valid read port. It then announces the start address of the register information to the engine. That address is a fixed upper constant joined with the fetched word. A fetched word that is not a multiple of four is reported as an error. When the engine signals completion, the unit clears either the originating peripheral's flag or that source's enable bit.

Top module: `actv_vector_unit`

## Requirements
- R1: A request whose enable bit is set never appears on `cpu_irq`. A request whose enable bit is clear appears on `cpu_irq` one clock after it is presented.
- R2: Among pending activations, the lowest-numbered enabled hardware source wins, and the software request wins only when no enabled hardware source is pending. No mask or priority input takes part in this choice.
- R3: For hardware source k, the vector fetch address is 0x0400 + 2·k.
- R4: For software activation, the fetch address is 0x0400 + (bits 6:0 of the activation register shifted left by one). A field of 0x10 gives 0x0420.
- R5: The software request flag (bit 7) is cleared in the cycle the software activation is accepted. A software write in that same cycle takes precedence over the clear.
- R6: `mem_req` stays high with a stable `mem_addr` until `mem_valid` is seen.
- R7: For an aligned word, `start_valid` pulses for one cycle, one clock after `mem_valid`. It carries `start_addr` = {0xFF, word} and `start_src` = source number, where 8 means software.
- R8: A fetched word with bit 1 or bit 0 set raises `vec_err` for one cycle instead of `start_valid`. It also clears that hardware source's enable bit.
- R9: On `eng_done`, if `eng_clr_en` is 1, the enable bit of the hardware source is cleared. If it is 0, `clr_flag` pulses for one cycle on that source's line. A software activation clears neither.
- R10: From acceptance until completion (or error), `busy` is high and no new source is chosen, even if a higher-priority request arrives.
- R11: After reset, the enables, the activation register, `cpu_irq`, `mem_req`, `start_valid`, `vec_err`, `clr_flag` and `busy` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NSRC | Peripheral request lines |
| cpu_irq | output | NSRC | Requests forwarded to the CPU interrupt path |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | NSRC | Enable register write data |
| en_q | output | NSRC | Enable register contents |
| sw_we | input | 1 | Activation register write strobe |
| sw_wdata | input | 8 | Activation register write data (bit 7 flag, bits 6:0 vector number) |
| sw_q | output | 8 | Activation register contents |
| mem_req | output | 1 | Vector read request |
| mem_addr | output | 16 | Vector read address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Fetched vector word |
| start_valid | output | 1 | Start address valid pulse to the engine |
| start_addr | output | 24 | Register information start address |
| start_src | output | 4 | Winning source number (NSRC means software) |
| vec_err | output | 1 | Misaligned vector pulse |
| eng_done | input | 1 | Engine completion strobe |
| eng_clr_en | input | 1 | On completion: 1 clears the enable bit, 0 clears the source flag |
| clr_flag | output | NSRC | One-cycle source flag clear pulses |
| busy | output | 1 | An activation is in progress |

## Verification
Two events can land in the same cycle: the unit accepting a software activation (and clearing its flag), and software writing the activation register. The bench provokes this by writing a new value exactly on the edge where the previous request is accepted. It then judges two things. The fetch address must come from the old vector number. The register must hold the newly written value with its flag set, so that a second activation follows with the new vector number. Preemption is also exercised by raising a higher-priority request during a fetch, which must leave the address and the winning source unchanged.

// File: rtl/actv_pkg.sv
package actv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2
  } actv_state_e;
endpackage

// File: rtl/actv_prio_pick.sv
module actv_prio_pick #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  logic [N:0]   seen;
  logic [N-1:0] grant;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]  = req[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req[i];
  end

  assign any = seen[N];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx = idx | IW'(i);
    end
  end
endmodule

// File: rtl/actv_vec_calc.sv
module actv_vec_calc #(
  parameter int              NSRC     = 8,
  parameter int              VA_W     = 16,
  parameter int              SWF_W    = 7,
  parameter logic [VA_W-1:0] VEC_BASE = 16'h0400,
  localparam int             IW       = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             is_sw,
  input  logic [IW-1:0]    hw_idx,
  input  logic [SWF_W-1:0] sw_field,
  output logic [VA_W-1:0]  vaddr
);
  logic [VA_W-1:0] hw_off, sw_off;

  assign hw_off = VA_W'({hw_idx, 1'b0});
  assign sw_off = VA_W'({sw_field, 1'b0});
  assign vaddr  = VEC_BASE + (is_sw ? sw_off : hw_off);
endmodule

// File: rtl/actv_src_regs.sv
module actv_src_regs #(
  parameter int NSRC  = 8,
  parameter int SWF_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_we,
  input  logic [NSRC-1:0]  en_wdata,
  input  logic [NSRC-1:0]  en_clr,
  input  logic             sw_we,
  input  logic [SWF_W:0]   sw_wdata,
  input  logic             sw_take,
  output logic [NSRC-1:0]  en_q,
  output logic [SWF_W:0]   sw_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
      sw_q <= '0;
    end else begin
      if (en_we) en_q <= en_wdata;
      else       en_q <= en_q & ~en_clr;
      if (sw_we)        sw_q        <= sw_wdata;
      else if (sw_take) sw_q[SWF_W] <= 1'b0;
    end
  end
endmodule

// File: rtl/actv_vector_unit.sv
module actv_vector_unit
  import actv_pkg::*;
#(
  parameter int                  NSRC     = 8,
  parameter int                  VA_W     = 16,
  parameter int                  SWF_W    = 7,
  parameter logic [VA_W-1:0]     VEC_BASE = 16'h0400,
  parameter int                  RAM_HI_W = 8,
  parameter logic [RAM_HI_W-1:0] RAM_HI   = 8'hFF
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NSRC-1:0]            irq_req,
  output logic [NSRC-1:0]            cpu_irq,
  input  logic                       en_we,
  input  logic [NSRC-1:0]            en_wdata,
  output logic [NSRC-1:0]            en_q,
  input  logic                       sw_we,
  input  logic [SWF_W:0]             sw_wdata,
  output logic [SWF_W:0]             sw_q,
  output logic                       mem_req,
  output logic [VA_W-1:0]            mem_addr,
  input  logic                       mem_valid,
  input  logic [VA_W-1:0]            mem_rdata,
  output logic                       start_valid,
  output logic [RAM_HI_W+VA_W-1:0]   start_addr,
  output logic [$clog2(NSRC+1)-1:0]  start_src,
  output logic                       vec_err,
  input  logic                       eng_done,
  input  logic                       eng_clr_en,
  output logic [NSRC-1:0]            clr_flag,
  output logic                       busy
);
  localparam int IW    = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int SRC_W = $clog2(NSRC + 1);

  actv_state_e     state;
  logic            sel_sw;
  logic [IW-1:0]   sel_idx;
  logic [NSRC-1:0] pend, sel_1h, en_clr;
  logic            hw_any, accept, misaligned;
  logic [IW-1:0]   hw_idx;
  logic [VA_W-1:0] vaddr;

  assign pend = irq_req & en_q;

  actv_prio_pick #(.N(NSRC)) u_pick (
    .req (pend),
    .any (hw_any),
    .idx (hw_idx)
  );

  actv_vec_calc #(
    .NSRC(NSRC), .VA_W(VA_W), .SWF_W(SWF_W), .VEC_BASE(VEC_BASE)
  ) u_vec (
    .is_sw    (~hw_any),
    .hw_idx   (hw_idx),
    .sw_field (sw_q[SWF_W-1:0]),
    .vaddr    (vaddr)
  );

  assign accept     = (state == ST_IDLE) && (hw_any || sw_q[SWF_W]);
  assign misaligned = |mem_rdata[1:0];
  assign sel_1h     = sel_sw ? '0 : (NSRC'(1) << sel_idx);

  always_comb begin
    en_clr = '0;
    if (state == ST_FETCH && mem_valid && misaligned) en_clr = sel_1h;
    if (state == ST_WAIT && eng_done && eng_clr_en)   en_clr = sel_1h;
  end

  actv_src_regs #(.NSRC(NSRC), .SWF_W(SWF_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .en_we    (en_we),
    .en_wdata (en_wdata),
    .en_clr   (en_clr),
    .sw_we    (sw_we),
    .sw_wdata (sw_wdata),
    .sw_take  (accept && !hw_any),
    .en_q     (en_q),
    .sw_q     (sw_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      sel_sw      <= 1'b0;
      sel_idx     <= '0;
      mem_req     <= 1'b0;
      mem_addr    <= '0;
      start_valid <= 1'b0;
      start_addr  <= '0;
      start_src   <= '0;
      vec_err     <= 1'b0;
      clr_flag    <= '0;
      cpu_irq     <= '0;
    end else begin
      start_valid <= 1'b0;
      vec_err     <= 1'b0;
      clr_flag    <= '0;
      cpu_irq     <= irq_req & ~en_q;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state    <= ST_FETCH;
            mem_req  <= 1'b1;
            mem_addr <= vaddr;
            sel_sw   <= ~hw_any;
            sel_idx  <= hw_idx;
          end
        end
        ST_FETCH: begin
          if (mem_valid) begin
            mem_req <= 1'b0;
            if (misaligned) begin
              vec_err <= 1'b1;
              state   <= ST_IDLE;
            end else begin
              start_valid <= 1'b1;
              start_addr  <= {RAM_HI, mem_rdata};
              start_src   <= sel_sw ? SRC_W'(NSRC) : SRC_W'(sel_idx);
              state       <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (eng_done) begin
            state <= ST_IDLE;
            if (!eng_clr_en) clr_flag <= sel_1h;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/actv_vector_unit_chk.sv
module actv_vector_unit_chk #(
  parameter int NSRC = 8,
  parameter int VA_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic [NSRC-1:0] cpu_irq,
  input logic [NSRC-1:0] en_q,
  input logic            mem_req,
  input logic [VA_W-1:0] mem_addr,
  input logic            mem_valid,
  input logic            start_valid,
  input logic            vec_err,
  input logic            eng_done,
  input logic [NSRC-1:0] clr_flag,
  input logic            busy
);
  // R1
  steer_excl_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((cpu_irq & $past(en_q)) == '0));

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  // R7
  start_after_data_chk: assert property (@(posedge clk) disable iff (rst)
    start_valid |-> $past(mem_req && mem_valid));

  // R7
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    start_valid |=> !start_valid);

  // R8
  err_no_start_chk: assert property (@(posedge clk) disable iff (rst)
    vec_err |-> (!start_valid && !busy));

  // R9
  clr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(clr_flag));

  // R9
  clr_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_flag != '0) |-> $past(eng_done));

  // R10
  no_rearb_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> $past(!busy));

  // R10
  req_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);
endmodule

bind actv_vector_unit actv_vector_unit_chk #(.NSRC(NSRC), .VA_W(VA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cpu_irq     (cpu_irq),
  .en_q        (en_q),
  .mem_req     (mem_req),
  .mem_addr    (mem_addr),
  .mem_valid   (mem_valid),
  .start_valid (start_valid),
  .vec_err     (vec_err),
  .eng_done    (eng_done),
  .clr_flag    (clr_flag),
  .busy        (busy)
);

// File: tb/tb_actv_vector_unit.sv
module tb_actv_vector_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  irq_req = '0, cpu_irq, en_wdata = '0, en_q, clr_flag;
  logic        en_we = 1'b0, sw_we = 1'b0;
  logic [7:0]  sw_wdata = '0, sw_q;
  logic        mem_req, mem_valid = 1'b0, start_valid, vec_err, busy;
  logic [15:0] mem_addr, mem_rdata = '0;
  logic [23:0] start_addr;
  logic [3:0]  start_src;
  logic        eng_done = 1'b0, eng_clr_en = 1'b0;

  int nchk = 0, nfail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  actv_vector_unit dut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .cpu_irq(cpu_irq),
    .en_we(en_we), .en_wdata(en_wdata), .en_q(en_q),
    .sw_we(sw_we), .sw_wdata(sw_wdata), .sw_q(sw_q),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .start_valid(start_valid), .start_addr(start_addr), .start_src(start_src),
    .vec_err(vec_err), .eng_done(eng_done), .eng_clr_en(eng_clr_en),
    .clr_flag(clr_flag), .busy(busy)
  );

  typedef struct packed {
    logic [7:0]  en;
    logic [7:0]  irq;
    logic [7:0]  sw;
    logic [15:0] rdata;
    logic [15:0] va;
    logic [3:0]  src;
    logic        err;
    logic        clr;
  } vec_t;

  localparam vec_t TBL [6] = '{
    '{8'h01, 8'h01, 8'h00, 16'h1230, 16'h0400, 4'd0, 1'b0, 1'b0},
    '{8'h0C, 8'h0C, 8'h00, 16'h2000, 16'h0404, 4'd2, 1'b0, 1'b1},
    '{8'h00, 8'hFF, 8'h90, 16'h4000, 16'h0420, 4'd8, 1'b0, 1'b0},
    '{8'hF0, 8'h30, 8'h00, 16'h0002, 16'h0408, 4'd4, 1'b1, 1'b0},
    '{8'hFF, 8'hA0, 8'h00, 16'hFFFC, 16'h040A, 4'd5, 1'b0, 1'b1},
    '{8'h00, 8'h00, 8'hFF, 16'h5558, 16'h04FE, 4'd8, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_req();
    int n = 0;
    while (!mem_req && n < 20) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        nchk++;
        nfail++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", {en_q, sw_q, cpu_irq}, 24'h0);
    chk("R11", {mem_req, start_valid, vec_err, busy, clr_flag}, 12'h0);
    rst = 1'b0;

    foreach (TBL[i]) begin
      automatic vec_t e = TBL[i];
      automatic logic [7:0] src1h = (e.src == 4'd8) ? 8'h00 : (8'h01 << e.src);
      @(negedge clk);
      en_we = 1'b1; en_wdata = e.en; irq_req = '0;
      @(negedge clk);
      en_we = 1'b0;
      if (e.sw != 8'h00) begin sw_we = 1'b1; sw_wdata = e.sw; end
      irq_req = e.irq;
      @(negedge clk);
      sw_we = 1'b0;
      wait_req();
      // R2 R3 R4: winner and address
      chk(e.src == 4'd8 ? "R4" : "R3", {mem_req, mem_addr}, {1'b1, e.va});
      // R1: steering
      chk("R1", cpu_irq, e.irq & ~e.en);
      chk("R10", busy, 1'b1);
      // R5: flag cleared on acceptance
      if (e.src == 4'd8) chk("R5", sw_q, e.sw & 8'h7F);
      mem_valid = 1'b1; mem_rdata = e.rdata;
      @(negedge clk);
      mem_valid = 1'b0; irq_req = '0;
      chk("R6", mem_req, 1'b0);
      if (e.err) begin
        // R8: misaligned vector
        chk("R8", {vec_err, start_valid}, 2'b10);
        chk("R8", en_q, e.en & ~src1h);
      end else begin
        // R7 R2: start report
        chk("R7", {vec_err, start_valid, start_addr}, {2'b01, 8'hFF, e.rdata});
        chk("R2", start_src, e.src);
        eng_done = 1'b1; eng_clr_en = e.clr;
        @(negedge clk);
        eng_done = 1'b0;
        // R9: clearing on completion
        chk("R9", clr_flag, e.clr ? 8'h00 : src1h);
        chk("R9", en_q, e.clr ? (e.en & ~src1h) : e.en);
        chk("R10", busy, 1'b0);
      end
    end

    // R5: software write on the acceptance edge takes precedence
    @(negedge clk);
    en_we = 1'b1; en_wdata = 8'h00;
    @(negedge clk);
    en_we = 1'b0; sw_we = 1'b1; sw_wdata = 8'h85;
    @(negedge clk);
    sw_wdata = 8'h93;
    @(negedge clk);
    sw_we = 1'b0;
    chk("R4", {mem_req, mem_addr}, {1'b1, 16'h040A});
    chk("R5", sw_q, 8'h93);
    mem_valid = 1'b1; mem_rdata = 16'h0100;
    @(negedge clk);
    mem_valid = 1'b0;
    chk("R7", {start_valid, start_addr, start_src}, {1'b1, 24'hFF0100, 4'd8});
    eng_done = 1'b1; eng_clr_en = 1'b0;
    @(negedge clk);
    eng_done = 1'b0;
    chk("R9", clr_flag, 8'h00);
    wait_req();
    chk("R5", {mem_addr, sw_q}, {16'h0426, 8'h13});
    mem_valid = 1'b1; mem_rdata = 16'h0104;
    @(negedge clk);
    mem_valid = 1'b0;
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;

    // R10: no preemption by a higher-priority request
    @(negedge clk);
    en_we = 1'b1; en_wdata = 8'h03;
    @(negedge clk);
    en_we = 1'b0; irq_req = 8'h02;
    @(negedge clk);
    wait_req();
    chk("R3", mem_addr, 16'h0402);
    irq_req = 8'h03;
    repeat (3) @(negedge clk);
    chk("R10", {mem_req, mem_addr}, {1'b1, 16'h0402});
    mem_valid = 1'b1; mem_rdata = 16'h0200;
    @(negedge clk);
    mem_valid = 1'b0; irq_req = 8'h01;
    chk("R10", start_src, 4'd1);
    eng_done = 1'b1; eng_clr_en = 1'b0;
    @(negedge clk);
    eng_done = 1'b0;
    chk("R9", clr_flag, 8'h02);
    wait_req();
    chk("R2", mem_addr, 16'h0400);
    mem_valid = 1'b1; mem_rdata = 16'h0300;
    @(negedge clk);
    mem_valid = 1'b0; irq_req = 8'h00;
    eng_done = 1'b1; eng_clr_en = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
    chk("R9", {clr_flag, en_q}, {8'h00, 8'h02});
    repeat (3) @(negedge clk);
    chk("R10", {busy, mem_req}, 2'b00);

    finish_run();
  end
endmodule